// File: doc/BRIEF.md
# Fault Input Glitch Filter

This block conditions a group of asynchronous fault inputs that feed the shutdown logic of a motor-control PWM stage. Each raw input first passes through a two-flop synchronizer. An optional stretcher can then widen single-cycle pulses. After that comes a digital filter. The filter samples its input once every `cfg_period` clock cycles and accepts a new level only when `cfg_count + 3` consecutive samples agree on it. A period of zero turns the filter off, and the status then tracks the synchronized input one cycle later.

Each input has a filtered status bit and a sticky fault flag. The flag is set on a rising edge of the filtered status and cleared by a write-one-to-clear pulse. In parallel with all of this, a purely combinational output asserts as soon as any raw input goes high. This lets the PWM outputs be disabled at once, even with no clock running. Configuration arrives as plain register-style inputs that are shared by all channels.

Top module: `fault_glitch_filter`

## Requirements
- R1: After a synchronous reset, every `pin_status` and `fault_flag` bit is 0.
- R2: With `cfg_period` = 0 (filter bypassed) and `cfg_stretch` = 0, a raw level change shows on `pin_status` 3 clock edges after it is applied: two synchronizer stages plus one output register. A one-cycle raw pulse gives a one-cycle status pulse.
- R3: With `cfg_period` = P ≠ 0 and `cfg_count` = C, a raw level change held long enough reaches `pin_status` no earlier than edge 3+(C+2)·P and no later than edge 2+(C+3)·P after it is applied. This holds for both rising and falling changes.
- R4: In filtered mode, a raw pulse shorter than one sample period never changes `pin_status` and never sets `fault_flag`.
- R5: `fault_flag[i]` sets in the same cycle that `pin_status[i]` rises, and it stays set after `pin_status[i]` falls.
- R6: A high `flag_clr[i]` clears `fault_flag[i]` at the next edge. If a filtered rising edge happens in that same cycle, the set wins.
- R7: `pwm_kill` is the combinational OR of the raw inputs. It does not depend on the clock, the reset or the filter settings.
- R8: With `cfg_stretch` = 1 and the filter bypassed, a one-cycle raw pulse holds `pin_status` high for exactly 2 cycles.
- R9: Writing `cfg_period` = 0 discards any partial filter progress. On the next edge, `pin_status` takes the current synchronized input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_raw | input | N_IN | Asynchronous fault inputs, active high |
| cfg_period | input | PER_W | Sample period in cycles; 0 bypasses the filter |
| cfg_count | input | CNT_W | Required agreeing samples minus 3 |
| cfg_stretch | input | 1 | Widen narrow pulses to at least 2 cycles |
| flag_clr | input | N_IN | Write-one-to-clear pulses for the fault flags |
| pwm_kill | output | 1 | Combinational OR of all raw fault inputs |
| pin_status | output | N_IN | Filtered fault level per input |
| fault_flag | output | N_IN | Sticky fault flag per input |

## Verification
A corrupted agreement counter or sample-tick phase shows up as `pin_status` moving outside the window of R3. The error can be as small as one sample period and as large as the whole (C+3)·P latency, so the bench checks both edges of that window. A stuck stretcher register makes the status pulse in bypass mode one cycle too long or too short, and this is visible within five edges of the stimulus. A wrong flag update shows as soon as the next clear pulse arrives or the next filtered rise occurs. The assertions pin the new status value to the stretcher's output and check that the flag keeps its sticky, set-wins behaviour.

// File: rtl/fgf_pkg.sv
package fgf_pkg;
  // Minimum number of agreeing samples added to the count setting.
  localparam int CNT_BIAS = 3;

  function automatic int agree_width(input int cnt_w);
    return $clog2((1 << cnt_w) + CNT_BIAS);
  endfunction
endpackage

// File: rtl/fgf_sync.sv
module fgf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/fgf_stretch.sv
module fgf_stretch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= d;
  end

  // A one-cycle high on d is extended by the held copy to two cycles.
  assign q = enable ? (d | hold_q) : d;
endmodule

// File: rtl/fgf_tick.sv
module fgf_tick #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (period != '0) && (cnt_q >= period - 1'b1);
  assign tick = wrap;

  always_ff @(posedge clk) begin
    if (rst || period == '0) cnt_q <= '0;
    else if (wrap)           cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fgf_chan.sv
module fgf_chan #(
  parameter int AG_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bypass,
  input  logic            tick,
  input  logic [AG_W-1:0] need_m1,
  input  logic            din,
  input  logic            clr,
  output logic            pin,
  output logic            flag
);
  logic [AG_W-1:0] agree_q;
  logic [AG_W-1:0] agree_d;
  logic            pin_d;

  always_comb begin
    pin_d   = pin;
    agree_d = agree_q;
    if (bypass) begin
      pin_d   = din;
      agree_d = '0;
    end else if (tick) begin
      if (din == pin) begin
        agree_d = '0;
      end else if (agree_q >= need_m1) begin
        pin_d   = din;
        agree_d = '0;
      end else begin
        agree_d = agree_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      agree_q <= '0;
      pin     <= 1'b0;
      flag    <= 1'b0;
    end else begin
      agree_q <= agree_d;
      pin     <= pin_d;
      flag    <= (pin_d & ~pin) | (flag & ~clr);
    end
  end
endmodule

// File: rtl/fault_glitch_filter.sv
module fault_glitch_filter #(
  parameter int N_IN  = 4,
  parameter int PER_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  fault_raw,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_stretch,
  input  logic [N_IN-1:0]  flag_clr,
  output logic             pwm_kill,
  output logic [N_IN-1:0]  pin_status,
  output logic [N_IN-1:0]  fault_flag
);
  import fgf_pkg::*;

  localparam int AG_W = agree_width(CNT_W);

  logic [N_IN-1:0] sync_q;
  logic [N_IN-1:0] filt_in;
  logic            tick;
  logic            bypass;
  logic [AG_W-1:0] need_m1;

  // Immediate shutdown straight from the raw pins.
  assign pwm_kill = |fault_raw;

  assign bypass  = (cfg_period == '0);
  assign need_m1 = AG_W'(cfg_count) + AG_W'(CNT_BIAS - 1);

  fgf_sync #(.W(N_IN)) u_sync (
    .clk(clk), .rst(rst), .d(fault_raw), .q(sync_q)
  );

  fgf_stretch #(.W(N_IN)) u_stretch (
    .clk(clk), .rst(rst), .enable(cfg_stretch), .d(sync_q), .q(filt_in)
  );

  fgf_tick #(.PER_W(PER_W)) u_tick (
    .clk(clk), .rst(rst), .period(cfg_period), .tick(tick)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_chan
    fgf_chan #(.AG_W(AG_W)) u_chan (
      .clk(clk), .rst(rst), .bypass(bypass), .tick(tick),
      .need_m1(need_m1), .din(filt_in[i]), .clr(flag_clr[i]),
      .pin(pin_status[i]), .flag(fault_flag[i])
    );
  end
endmodule

// File: rtl/fgf_checker.sv
module fgf_checker #(
  parameter int N_IN = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [N_IN-1:0] filt_in,
  input logic [N_IN-1:0] flag_clr,
  input logic [N_IN-1:0] pin_status,
  input logic [N_IN-1:0] fault_flag
);
  for (genvar i = 0; i < N_IN; i++) begin : g_chk
    // R5: a flag can only appear together with a high filtered status
    a_r5_flag_with_pin: assert property (@(posedge clk) disable iff (rst)
      $rose(fault_flag[i]) |-> pin_status[i]);

    // R5: without a clear the flag is sticky
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (fault_flag[i] && !flag_clr[i]) |=> fault_flag[i]);

    // R6: a clear empties the flag unless a rise happens at the same edge
    a_r6_clear_or_set: assert property (@(posedge clk) disable iff (rst)
      flag_clr[i] |=> (!fault_flag[i] || $rose(pin_status[i])));

    // R3: any new filtered level is the level the filter was being fed
    a_r3_pin_from_input: assert property (@(posedge clk) disable iff (rst)
      (pin_status[i] != $past(pin_status[i])) |-> (pin_status[i] == $past(filt_in[i])));
  end
endmodule

bind fault_glitch_filter fgf_checker #(.N_IN(N_IN)) u_fgf_checker (
  .clk(clk), .rst(rst), .filt_in(filt_in), .flag_clr(flag_clr),
  .pin_status(pin_status), .fault_flag(fault_flag)
);

// File: tb/tb_fault_glitch_filter.sv
`timescale 1ns/1ps
module tb_fault_glitch_filter;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [N-1:0] fault_raw;
  logic [7:0] cfg_period;
  logic [2:0] cfg_count;
  logic       cfg_stretch;
  logic [N-1:0] flag_clr;
  logic       pwm_kill;
  logic [N-1:0] pin_status;
  logic [N-1:0] fault_flag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fault_glitch_filter #(.N_IN(N), .PER_W(8), .CNT_W(3)) dut (
    .clk(clk), .rst(rst), .fault_raw(fault_raw), .cfg_period(cfg_period),
    .cfg_count(cfg_count), .cfg_stretch(cfg_stretch), .flag_clr(flag_clr),
    .pwm_kill(pwm_kill), .pin_status(pin_status), .fault_flag(fault_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    @(negedge clk);
    fault_raw = '0;
    cfg_period = 8'd0;
    cfg_stretch = 1'b0;
    edges(4);
    @(negedge clk);
    flag_clr = '1;
    @(negedge clk);
    flag_clr = '0;
  endtask

  task automatic t_reset();
    #1;
    chk("R7 kill during reset", int'(pwm_kill), 0);
    fault_raw = 4'b0001;
    #1;
    chk("R7 kill without clock edge", int'(pwm_kill), 1);
    fault_raw = '0;
    #1;
    chk("R7 kill release", int'(pwm_kill), 0);
    edges(3);
    @(negedge clk);
    rst = 1'b0;
    edges(1);
    chk("R1 pin_status after reset", int'(pin_status), 0);
    chk("R1 fault_flag after reset", int'(fault_flag), 0);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    fault_raw[0] = 1'b1;
    #1;
    chk("R7 kill follows raw", int'(pwm_kill), 1);
    edges(2);
    chk("R2 bypass not yet", int'(pin_status[0]), 0);
    edges(1);
    chk("R2 bypass 3-edge latency", int'(pin_status[0]), 1);
    chk("R5 flag set with pin", int'(fault_flag[0]), 1);
    @(negedge clk);
    fault_raw[0] = 1'b0;
    edges(3);
    chk("R2 bypass release", int'(pin_status[0]), 0);
    chk("R5 flag sticky after fall", int'(fault_flag[0]), 1);
    clear_all();
    #1;
    chk("R6 flag cleared", int'(fault_flag[0]), 0);
  endtask

  task automatic t_stretch(input bit st);
    @(negedge clk);
    cfg_period = 8'd0;
    cfg_stretch = st;
    edges(2);
    @(negedge clk);
    fault_raw[2] = 1'b1;
    @(negedge clk);
    fault_raw[2] = 1'b0;
    edges(2); // third edge since the pulse was applied
    chk(st ? "R8 stretch first cycle" : "R2 pulse first cycle", int'(pin_status[2]), 1);
    edges(1);
    chk(st ? "R8 stretch second cycle" : "R2 pulse one cycle", int'(pin_status[2]), st ? 1 : 0);
    edges(1);
    chk(st ? "R8 stretch ends" : "R2 pulse ended", int'(pin_status[2]), 0);
    clear_all();
  endtask

  task automatic t_filter(input int ch, input int p, input int c);
    int need = c + 3;
    @(negedge clk);
    cfg_period = 8'(p);
    cfg_count = 3'(c);
    edges(p + 2);
    @(negedge clk);
    fault_raw[ch] = 1'b1;
    edges(2 + (need - 1) * p);
    chk("R3 rise not before window", int'(pin_status[ch]), 0);
    edges(p);
    chk("R3 rise by window end", int'(pin_status[ch]), 1);
    chk("R5 flag on filtered rise", int'(fault_flag[ch]), 1);
    @(negedge clk);
    fault_raw[ch] = 1'b0;
    edges(2 + (need - 1) * p);
    chk("R3 fall not before window", int'(pin_status[ch]), 1);
    edges(p);
    chk("R3 fall by window end", int'(pin_status[ch]), 0);
    clear_all();
  endtask

  task automatic t_reject();
    @(negedge clk);
    cfg_period = 8'd4;
    cfg_count = 3'd0;
    edges(6);
    @(negedge clk);
    fault_raw[2] = 1'b1;
    repeat (3) @(negedge clk);
    fault_raw[2] = 1'b0;
    edges(30);
    chk("R4 short pulse rejected pin", int'(pin_status[2]), 0);
    chk("R4 short pulse rejected flag", int'(fault_flag[2]), 0);
    clear_all();
  endtask

  task automatic t_zero_clears();
    @(negedge clk);
    cfg_period = 8'd8;
    cfg_count = 3'd7;
    edges(3);
    @(negedge clk);
    fault_raw[3] = 1'b1;
    edges(12);
    chk("R9 still filtering", int'(pin_status[3]), 0);
    @(negedge clk);
    cfg_period = 8'd0;
    edges(1);
    chk("R9 zero period follows input", int'(pin_status[3]), 1);
    clear_all();
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    cfg_period = 8'd0;
    flag_clr[1] = 1'b1;
    fault_raw[1] = 1'b1;
    edges(3);
    chk("R6 set wins over clear", int'(fault_flag[1]), 1);
    @(negedge clk);
    flag_clr[1] = 1'b0;
    edges(2);
    chk("R6 flag holds after clear drops", int'(fault_flag[1]), 1);
    @(negedge clk);
    flag_clr[1] = 1'b1;
    @(negedge clk);
    flag_clr[1] = 1'b0;
    #1;
    chk("R6 clear while level held", int'(fault_flag[1]), 0);
    chk("R6 status unaffected by clear", int'(pin_status[1]), 1);
    clear_all();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    fault_raw = '0;
    cfg_period = 8'd0;
    cfg_count = 3'd0;
    cfg_stretch = 1'b0;
    flag_clr = '0;
    t_reset();
    t_bypass();
    t_stretch(1'b0);
    t_stretch(1'b1);
    t_filter(1, 2, 0);
    t_filter(0, 3, 7);
    t_filter(3, 5, 2);
    t_reject();
    t_zero_clears();
    t_set_wins();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule